// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to a synchronous burst memory array. A burst begins when either of two start strobes is high at a rising clock edge. At that edge the external address is captured: its upper bits become the fixed row of the burst, and its two low bits become the starting offset within a group of four words. On each later edge where the step input is high, the block moves to the next beat of the burst. When neither a strobe nor the step input is high, the address is held.

The order in which the four word positions are visited depends on a static order pin. This pin is not registered and steers the output directly. With the pin low, beats count upward from the offset and wrap within the group. With the pin high, each beat's position is the offset XORed with the beat number. After the fourth beat the sequence returns to the starting offset. The row bits never receive a carry.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, all state clears, so that `mem_addr` reads 0 in the cycle after that edge.
- R2: A rising edge with `start_a` or `start_b` high (and `rst_n` high) loads `addr_in`. `mem_addr` then equals the captured `addr_in` in either order mode. Either strobe alone is sufficient.
- R3: Between loads, `mem_addr[ADDR_W-1:2]` keeps the captured row value whatever `addr_in` does.
- R4: With `order_sel` = 0 (linear), `mem_addr[1:0]` equals (start offset + beat count) modulo 4.
- R5: With `order_sel` = 1 (interleaved), `mem_addr[1:0]` equals the start offset XOR the beat count.
- R6: The beat count goes up by one only at an edge where `step` is high and no strobe is high. An edge with no strobe and no step leaves `mem_addr` unchanged and ignores `addr_in`.
- R7: A step taken from beat 3 returns the beat count to 0, so the low bits go back to the start offset with no carry into the row bits.
- R8: When a strobe and `step` are high at the same edge, the load wins: the new address appears with beat count 0.
- R9: `order_sel` is not registered. A change on it alters `mem_addr[1:0]` within the same cycle, with no clock edge needed.
- R10: While `rst_n` is low, strobes and `step` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_a | input | 1 | First burst start strobe |
| start_b | input | 1 | Second burst start strobe |
| step | input | 1 | Advance to the next beat |
| order_sel | input | 1 | 0 = linear, 1 = interleaved (unregistered) |
| addr_in | input | ADDR_W | External word address captured on a load |
| mem_addr | output | ADDR_W | Current array word address |

## Verification
The effect of a load, a step or a hold on `mem_addr` appears one rising edge after the inputs are applied, because the strobes, the step input and the address pass through one register stage. The bench therefore drives each stimulus at a falling edge and samples 1 ns after the next rising edge, before the following falling edge applies new inputs. The order pin is the exception: it acts within the cycle. Its checks toggle the pin between edges and sample 1 ns later, with no rising edge in between.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package burst_seq_pkg;

    // Beat ordering selected by the unregistered order pin.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    // Edge command decoded from the strobes and the step input.
    typedef struct packed {
        logic load;   // capture a new external address
        logic adv;    // move to the next beat
    } seq_cmd_t;

endpackage

// File: rtl/burst_cmd_decode.sv
// Module: burst_cmd_decode
// Turns the two start strobes and the step input into one command.
// A load outranks an advance. Reset masks both.
// Assumes: inputs are synchronous to the clock of the consuming registers.
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic     rst_n,
    input  logic     start_a,
    input  logic     start_b,
    input  logic     step,
    output seq_cmd_t cmd
);

    // Purpose: merge strobes, give loads priority, mask everything in reset.
    always_comb begin
        cmd.load = rst_n & (start_a | start_b);
        cmd.adv  = rst_n & step & ~(start_a | start_b);
    end

    // R8: load and advance are never issued together
    always_comb begin
        assert_cmd_exclusive_R8: assert (!(cmd.load && cmd.adv));
    end

endmodule

// File: rtl/burst_origin_reg.sv
// Module: burst_origin_reg
// Holds the row bits and the start offset of the current burst.
// Both are captured on a load and kept until the next load.
// Assumes: ADDR_W > OFS_W.
module burst_origin_reg #(
    parameter int ADDR_W = 17,
    parameter int OFS_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       addr_in,
    output logic [ADDR_W-OFS_W-1:0] row_q,
    output logic [OFS_W-1:0]        start_q
);

    // Purpose: capture the burst origin on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            start_q <= '0;
        end else if (load) begin
            row_q   <= addr_in[ADDR_W-1:OFS_W];
            start_q <= addr_in[OFS_W-1:0];
        end
    end

    // R3: the row bits do not move between loads
    assert_row_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(row_q));

    // R2: a load captures the external address
    assert_origin_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (row_q == $past(addr_in[ADDR_W-1:OFS_W])) && (start_q == $past(addr_in[OFS_W-1:0])));

endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Counts the beats of a burst. A load clears it and an advance
// increments it, wrapping within CNT_W bits.
// Assumes: load and adv arrive already prioritised.
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [CNT_W-1:0] beat_q
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Purpose: clear on reset or load, step on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            beat_q <= '0;
        end else if (adv) begin
            beat_q <= beat_q + ONE;
        end
    end

    // R6: with neither load nor advance the beat count holds
    assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(beat_q));

    // R6: an advance moves exactly one beat
    assert_beat_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv) |=> (beat_q == $past(beat_q) + ONE));

    // R7: the last beat wraps to zero
    assert_beat_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && (beat_q == {CNT_W{1'b1}})) |=> (beat_q == '0));

    // R8: a load restarts the count even if advance is present
    assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0));

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps start offset and beat count to the low address bits.
// Linear mode adds them modulo 2**W. Interleaved mode XORs them.
// Purely combinational, so the order pin acts within the cycle.
// Assumes: start and beat have the same width W.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int W = 2
) (
    input  order_e         mode,
    input  logic [W-1:0]   start,
    input  logic [W-1:0]   beat,
    output logic [W-1:0]   low
);

    logic [W-1:0] lin_pos;
    logic [W-1:0] xor_pos;

    // Purpose: linear position, start plus beat, truncated to W bits.
    always_comb begin
        lin_pos = start + beat;
    end

    // Purpose: interleaved position, built bit by bit.
    for (genvar i = 0; i < W; i++) begin : g_xor_bit
        assign xor_pos[i] = start[i] ^ beat[i];
    end

    // Purpose: pick the ordering named by the mode pin.
    always_comb begin
        low = (mode == ORD_XOR) ? xor_pos : lin_pos;
    end

    // R4/R5: beat 0 always lands on the start offset in either mode
    always_comb begin
        if (beat == '0) begin
            assert_first_beat_R4: assert (low == start);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Generates the word address for a 4-beat synchronous burst memory.
// Strobes, step and address are registered on the rising edge.
// The order pin is combinational.
// Assumes: one clock; a synchronous active-low reset.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_a,
    input  logic              start_b,
    input  logic              step,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int ROW_W = ADDR_W - CNT_W;

    seq_cmd_t         cmd;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] beat_q;
    logic [CNT_W-1:0] low_bits;
    order_e           mode;

    // Purpose: present the raw order pin as the ordering type.
    always_comb begin
        mode = order_e'(order_sel);
    end

    burst_cmd_decode u_dec (
        .rst_n   (rst_n),
        .start_a (start_a),
        .start_b (start_b),
        .step    (step),
        .cmd     (cmd)
    );

    burst_origin_reg #(.ADDR_W(ADDR_W), .OFS_W(CNT_W)) u_origin (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd.load),
        .addr_in (addr_in),
        .row_q   (row_q),
        .start_q (start_q)
    );

    burst_beat_ctr #(.CNT_W(CNT_W)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cmd.load),
        .adv    (cmd.adv),
        .beat_q (beat_q)
    );

    burst_order_map #(.W(CNT_W)) u_map (
        .mode  (mode),
        .start (start_q),
        .beat  (beat_q),
        .low   (low_bits)
    );

    // Purpose: join the fixed row and the ordered low bits.
    always_comb begin
        mem_addr = {row_q, low_bits};
    end

    // R2: after either strobe the output equals the sampled address
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_a || start_b) |=> (mem_addr == $past(addr_in)));

    // R1: reset leaves address zero at the next edge
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_addr == '0));

endmodule

// File: tb/sim_burst_addr_seq.sv
// Self-checking bench for burst_addr_seq: a vector table, then directed tests.
module sim_burst_addr_seq;

    localparam int AW = 17;
    localparam int NV = 14;
    // Packed vector: {start_a, start_b, step, order_sel, addr_in[16:0], expect[16:0]}
    localparam logic [37:0] VEC [NV] = '{
        {4'b1000, 17'h12342, 17'h12342},  // R2 load via start_a, offset 2
        {4'b0010, 17'h00000, 17'h12343},  // R4 linear beat 1
        {4'b0010, 17'h1FFFF, 17'h12340},  // R4 linear wrap of low bits, R3 row kept
        {4'b0010, 17'h00000, 17'h12341},  // R4 linear beat 3
        {4'b0010, 17'h00000, 17'h12342},  // R7 back to start offset
        {4'b0000, 17'h1FFFF, 17'h12342},  // R6 hold, addr_in ignored
        {4'b0101, 17'h0AB01, 17'h0AB01},  // R2 load via start_b, interleaved
        {4'b0011, 17'h00000, 17'h0AB00},  // R5 1^1
        {4'b0011, 17'h00000, 17'h0AB03},  // R5 1^2
        {4'b0011, 17'h00000, 17'h0AB02},  // R5 1^3
        {4'b0011, 17'h00000, 17'h0AB01},  // R7 interleaved wrap
        {4'b1010, 17'h15557, 17'h15557},  // R8 start_a beats step
        {4'b0110, 17'h00002, 17'h00002},  // R8 start_b beats step
        {4'b0010, 17'h00000, 17'h00003}   // R4 step after priority load
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_a = 1'b0;
    logic          start_b = 1'b0;
    logic          step = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 4 ns period

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_a   (start_a),
        .start_b   (start_b),
        .step      (step),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .mem_addr  (mem_addr)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        checks++;
        if (mem_addr !== exp) begin
            failures++;
            $display("FAIL %s: mem_addr=%h expected=%h", req, mem_addr, exp);
        end
    endtask

    // Apply inputs at a falling edge, then sample 1 ns after the rising edge.
    task automatic cycle(input logic a, input logic b, input logic s,
                         input logic m, input logic [AW-1:0] ad);
        @(negedge clk);
        start_a = a; start_b = b; step = s; order_sel = m; addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state
        cycle(1'b0, 1'b0, 1'b0, 1'b0, '0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R1", '0);
        // R10: strobe and step during reset do nothing
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 17'h1ABCD);
        check("R10", '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:17]);
            check($sformatf("R2-R8 vector %0d", i), VEC[i][16:0]);
        end

        // R9: order pin acts without a clock edge. Load offset 1, one step -> beat 1
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 17'h04441);
        cycle(1'b0, 1'b0, 1'b1, 1'b0, '0);
        check("R9 linear", 17'h04442);
        @(negedge clk);
        start_a = 1'b0; step = 1'b0; order_sel = 1'b1;
        #1;
        check("R9 interleaved", 17'h04440);
        order_sel = 1'b0;
        #0.5;
        check("R9 back to linear", 17'h04442);

        // R3: row kept across a full burst while addr_in toggles
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 17'h1FFFC);
        check("R3", 17'h04443);
        // R7: carry must not reach the row bits
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 17'h1FFFC);
        check("R7 no carry", 17'h04440);

        // R1: reset mid-burst clears the address
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-burst", '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: load works again after reset
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 17'h0F0F3);
        check("R2 after reset", 17'h0F0F3);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule